// File: doc/BRIEF.md
# Multi-cycle RV32I integer core

A non-pipelined 32-bit processor for the RV32I base integer instruction set. Each instruction goes through five phases in turn: fetch, decode, execute, memory access and writeback. Fetch copies the program counter into the memory address register and reads the instruction word. Decode reads both source registers and builds the sign-extended immediate. Execute computes the ALU result, the effective address and the next program counter. The memory phase runs only for loads and stores. Writeback updates the destination register and the program counter.

The core has one word-wide memory port. It carries a request, a byte address, a write strobe, a 4-bit byte-enable mask, write data, read data and a ready handshake. A transfer completes in a cycle where both the request and ready are high. The core stops on ECALL and EBREAK and raises `halt_o`. It stops with `fault_o` on a misaligned load or store and on an opcode outside RV32I. FENCE executes as a no-op.

Top module: `rv_mc_core`

## Requirements
- R1: While `rst_ni` is low, every register reads as zero, the program counter holds `RESET_VEC`, and `halt_o` and `fault_o` are low. A register never written after reset reads 0 when it is stored.
- R2: The first request after reset is a read (`mem_we_o`=0) at address `RESET_VEC`.
- R3: Register-register and register-immediate arithmetic, logic, compare and shift instructions give the RV32I results. SLT/SLTI compare signed. SLTU compares unsigned. SLTIU compares rs1 unsigned against the sign-extended immediate. Register shift amounts use rs2 modulo 32. SRL/SRLI fill with zeros and SRA/SRAI fill with the sign bit.
- R4: LUI writes the immediate with its low 12 bits zero. AUIPC writes the instruction's PC plus that immediate.
- R5: A branch (BEQ, BNE, BLT, BGE, BLTU, BGEU) that is taken adds its immediate to PC. A branch that is not taken, and every instruction that is not a jump, continues at PC+4.
- R6: JAL and JALR write PC+4 to rd. The JALR target is rs1+imm with bit 0 cleared.
- R7: Loads pick the byte or halfword lane given by address bits [1:0]. LB/LH sign-extend and LBU/LHU zero-extend.
- R8: Stores place the data in the lane of the address. The byte enable is 0001 shifted left by the byte offset for SB, 0011 or 1100 for SH, and 1111 for SW. Bytes that are not enabled are kept.
- R9: A write to x0 is discarded, so x0 always reads 0.
- R10: ECALL and EBREAK raise `halt_o` with `fault_o` low. After that the core makes no further memory request.
- R11: A halfword access at an odd address, or a word access at an address that is not a multiple of 4, raises `fault_o` and `halt_o`. It performs no memory write and no later instruction runs.
- R12: While a request is pending without ready, the request and its address, strobe, enables and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Memory request valid |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_we_o | output | 1 | 1 for a store, 0 for a read |
| mem_be_o | output | 4 | Byte-enable mask for stores |
| mem_wdata_o | output | 32 | Store data, already in its byte lane |
| mem_rdata_i | input | 32 | Read data, valid when ready is high |
| mem_ready_i | input | 1 | Transfer completes this cycle |
| halt_o | output | 1 | Core has stopped |
| fault_o | output | 1 | The stop was caused by a misaligned or illegal instruction |

## Verification
Register contents are reachable only through stores. Every test program therefore ends each computation with a store to a results area that is pre-filled with a marker, and the bench compares memory after the halt. The hardest points to reach are the hold behaviour under back-pressure and the interaction of PC-relative jumps with the exact instruction addresses. Ready is withheld at random on every request. The program builder records the address of each instruction it emits, so link values and AUIPC results can be predicted. Misaligned accesses and the halt are checked by counting memory writes and requests after the stop.

// File: rtl/rv_core_pkg.sv
package rv_core_pkg;
  typedef enum logic [2:0] {PH_FETCH, PH_DECODE, PH_EXEC, PH_MEM, PH_WB, PH_HALT} phase_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;

  localparam logic [6:0] OPC_LUI   = 7'h37;
  localparam logic [6:0] OPC_AUIPC = 7'h17;
  localparam logic [6:0] OPC_JAL   = 7'h6f;
  localparam logic [6:0] OPC_JALR  = 7'h67;
  localparam logic [6:0] OPC_BR    = 7'h63;
  localparam logic [6:0] OPC_LD    = 7'h03;
  localparam logic [6:0] OPC_ST    = 7'h23;
  localparam logic [6:0] OPC_OPI   = 7'h13;
  localparam logic [6:0] OPC_OP    = 7'h33;
  localparam logic [6:0] OPC_FENCE = 7'h0f;
  localparam logic [6:0] OPC_SYS   = 7'h73;
endpackage

// File: rtl/rv_alu.sv
module rv_alu
  import rv_core_pkg::*;
#(
  parameter int XW = 32
) (
  input  alu_op_e         op_i,
  input  logic [XW-1:0]   a_i,
  input  logic [XW-1:0]   b_i,
  output logic [XW-1:0]   y_o
);
  localparam int SHW = $clog2(XW);

  logic [SHW-1:0] sh;
  assign sh = b_i[SHW-1:0];  // shift amount modulo XW

  always_comb begin
    case (op_i)
      ALU_SUB:  y_o = a_i - b_i;
      ALU_SLL:  y_o = a_i << sh;
      ALU_SLT:  y_o = {{(XW-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLTU: y_o = {{(XW-1){1'b0}}, a_i < b_i};
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_SRL:  y_o = a_i >> sh;
      ALU_SRA:  y_o = XW'($signed(a_i) >>> sh);
      ALU_OR:   y_o = a_i | b_i;
      ALU_AND:  y_o = a_i & b_i;
      default:  y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/rv_imm_gen.sv
module rv_imm_gen
  import rv_core_pkg::*;
(
  input  logic [31:0] ir_i,
  output logic [31:0] imm_o
);
  always_comb begin
    case (ir_i[6:0])
      OPC_LUI, OPC_AUIPC: imm_o = {ir_i[31:12], 12'h000};
      OPC_JAL:  imm_o = {{12{ir_i[31]}}, ir_i[19:12], ir_i[20], ir_i[30:21], 1'b0};
      OPC_BR:   imm_o = {{20{ir_i[31]}}, ir_i[7], ir_i[30:25], ir_i[11:8], 1'b0};
      OPC_ST:   imm_o = {{20{ir_i[31]}}, ir_i[31:25], ir_i[11:7]};
      default:  imm_o = {{20{ir_i[31]}}, ir_i[31:20]};
    endcase
  end
endmodule

// File: rtl/rv_regfile.sv
module rv_regfile #(
  parameter int NREG = 32,
  parameter int XW   = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] waddr_i,
  input  logic [XW-1:0]  wdata_i,
  input  logic [RAW-1:0] raddr_a_i,
  input  logic [RAW-1:0] raddr_b_i,
  output logic [XW-1:0]  rdata_a_o,
  output logic [XW-1:0]  rdata_b_o
);
  logic [XW-1:0] regs [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++)
        if (we_i && waddr_i == RAW'(i)) regs[i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/rv_mc_core.sv
module rv_mc_core
  import rv_core_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000,
  parameter int          NREG      = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  output logic        mem_we_o,
  output logic [3:0]  mem_be_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ready_i,
  output logic        halt_o,
  output logic        fault_o
);
  localparam int RAW = $clog2(NREG);

  phase_e      phase_q;
  logic [31:0] pc_q, pc_nxt_q, ir_q, mar_q, mdr_q, a_q, b_q, imm_q, res_q;
  logic [3:0]  be_q;
  logic        fault_q;

  logic [6:0]  opc;
  logic [2:0]  f3;
  logic [31:0] rf_a, rf_b, imm_w, alu_y, eff, pc_nxt, res_w, st_data, ld_val, lane_w;
  logic [3:0]  be_w;
  alu_op_e     alu_op;
  logic        br_take, lsu_bad, legal, is_ld, is_st, wr_rd, is_ctrl;

  assign opc   = ir_q[6:0];
  assign f3    = ir_q[14:12];
  assign is_ld = (opc == OPC_LD);
  assign is_st = (opc == OPC_ST);
  assign is_ctrl = (opc == OPC_JAL) || (opc == OPC_JALR) || (opc == OPC_BR);

  rv_regfile #(.NREG(NREG), .XW(32)) u_rf (
    .clk_i, .rst_ni,
    .we_i      (phase_q == PH_WB && wr_rd),
    .waddr_i   (ir_q[7 +: RAW]),
    .wdata_i   (is_ld ? ld_val : res_q),
    .raddr_a_i (ir_q[15 +: RAW]),
    .raddr_b_i (ir_q[20 +: RAW]),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b)
  );

  rv_imm_gen u_imm (.ir_i(ir_q), .imm_o(imm_w));

  always_comb begin
    case (f3)
      3'd1:    alu_op = ALU_SLL;
      3'd2:    alu_op = ALU_SLT;
      3'd3:    alu_op = ALU_SLTU;
      3'd4:    alu_op = ALU_XOR;
      3'd5:    alu_op = ir_q[30] ? ALU_SRA : ALU_SRL;
      3'd6:    alu_op = ALU_OR;
      3'd7:    alu_op = ALU_AND;
      default: alu_op = (opc == OPC_OP && ir_q[30]) ? ALU_SUB : ALU_ADD;
    endcase
  end

  rv_alu #(.XW(32)) u_alu (
    .op_i (alu_op),
    .a_i  (a_q),
    .b_i  (opc == OPC_OP ? b_q : imm_q),
    .y_o  (alu_y)
  );

  always_comb begin
    case (f3)
      3'd0:    br_take = (a_q == b_q);
      3'd1:    br_take = (a_q != b_q);
      3'd4:    br_take = ($signed(a_q) <  $signed(b_q));
      3'd5:    br_take = ($signed(a_q) >= $signed(b_q));
      3'd6:    br_take = (a_q <  b_q);
      3'd7:    br_take = (a_q >= b_q);
      default: br_take = 1'b0;
    endcase
  end

  assign eff = a_q + imm_q;

  always_comb begin
    case (f3[1:0])
      2'd0:    begin lsu_bad = 1'b0;    be_w = 4'b0001 << eff[1:0]; end
      2'd1:    begin lsu_bad = eff[0];  be_w = 4'b0011 << eff[1:0]; end
      2'd2:    begin lsu_bad = |eff[1:0]; be_w = 4'b1111; end
      default: begin lsu_bad = 1'b1;    be_w = 4'b0000; end
    endcase
  end
  assign st_data = b_q << {eff[1:0], 3'b000};

  always_comb begin
    case (opc)
      OPC_JAL:  pc_nxt = pc_q + imm_q;
      OPC_JALR: pc_nxt = eff & ~32'd1;
      OPC_BR:   pc_nxt = br_take ? pc_q + imm_q : pc_q + 32'd4;
      default:  pc_nxt = pc_q + 32'd4;
    endcase
    case (opc)
      OPC_LUI:           res_w = imm_q;
      OPC_AUIPC:         res_w = pc_q + imm_q;
      OPC_JAL, OPC_JALR: res_w = pc_q + 32'd4;
      default:           res_w = alu_y;
    endcase
  end

  always_comb begin
    case (opc)
      OPC_LUI, OPC_AUIPC, OPC_JAL, OPC_JALR, OPC_BR, OPC_LD, OPC_ST,
      OPC_OPI, OPC_OP, OPC_FENCE, OPC_SYS: legal = 1'b1;
      default: legal = 1'b0;
    endcase
    case (opc)
      OPC_LUI, OPC_AUIPC, OPC_JAL, OPC_JALR, OPC_LD, OPC_OPI, OPC_OP: wr_rd = 1'b1;
      default: wr_rd = 1'b0;
    endcase
  end

  // load lane extraction
  assign lane_w = mdr_q >> {mar_q[1:0], 3'b000};
  always_comb begin
    case (f3)
      3'd0:    ld_val = {{24{lane_w[7]}}, lane_w[7:0]};
      3'd1:    ld_val = {{16{lane_w[15]}}, lane_w[15:0]};
      3'd4:    ld_val = {24'h0, lane_w[7:0]};
      3'd5:    ld_val = {16'h0, lane_w[15:0]};
      default: ld_val = mdr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_FETCH;
      pc_q     <= RESET_VEC;
      mar_q    <= RESET_VEC;
      pc_nxt_q <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      imm_q    <= '0;
      res_q    <= '0;
      be_q     <= '0;
      fault_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_FETCH: if (mem_ready_i) begin
          ir_q    <= mem_rdata_i;
          mdr_q   <= mem_rdata_i;
          phase_q <= PH_DECODE;
        end
        PH_DECODE: begin
          a_q     <= rf_a;
          b_q     <= rf_b;
          imm_q   <= imm_w;
          phase_q <= PH_EXEC;
        end
        PH_EXEC: begin
          pc_nxt_q <= pc_nxt;
          res_q    <= res_w;
          if (opc == OPC_SYS) begin
            phase_q <= PH_HALT;
          end else if (!legal || ((is_ld || is_st) && lsu_bad)) begin
            fault_q <= 1'b1;
            phase_q <= PH_HALT;
          end else if (is_ld || is_st) begin
            mar_q   <= eff;
            mdr_q   <= st_data;
            be_q    <= be_w;
            phase_q <= PH_MEM;
          end else begin
            phase_q <= PH_WB;
          end
        end
        PH_MEM: if (mem_ready_i) begin
          if (is_ld) mdr_q <= mem_rdata_i;
          phase_q <= PH_WB;
        end
        PH_WB: begin
          pc_q    <= pc_nxt_q;
          mar_q   <= pc_nxt_q;
          phase_q <= PH_FETCH;
        end
        default: phase_q <= PH_HALT;
      endcase
    end
  end

  assign mem_req_o   = (phase_q == PH_FETCH) || (phase_q == PH_MEM);
  assign mem_addr_o  = mar_q;
  assign mem_we_o    = (phase_q == PH_MEM) && is_st;
  assign mem_be_o    = mem_we_o ? be_q : 4'hf;
  assign mem_wdata_o = mdr_q;
  assign halt_o      = (phase_q == PH_HALT);
  assign fault_o     = fault_q;

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                  && $stable(mem_be_o) && $stable(mem_wdata_o));
  // R10
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && !mem_req_o);
  // R11
  fault_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> halt_o);
  // R8
  store_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_be_o == 4'b0001 || mem_be_o == 4'b0010 || mem_be_o == 4'b0100 ||
                  mem_be_o == 4'b1000 || mem_be_o == 4'b0011 || mem_be_o == 4'b1100 ||
                  mem_be_o == 4'b1111));
  // R5
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_WB && !is_ctrl |=> mem_addr_o == $past(pc_q) + 32'd4);
endmodule

// File: tb/rv_mc_core_test.sv
`timescale 1ns/1ps
module rv_mc_core_test;
  localparam logic [31:0] RV = 32'h0000_0040;
  localparam int RES = 'h600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_req, mem_we, mem_ready = 1'b0, halt, fault;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0] mem_be;

  always #10 clk = ~clk;

  rv_mc_core #(.RESET_VEC(RV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready), .halt_o(halt), .fault_o(fault)
  );

  logic [31:0] mem [1024];
  int n_chk = 0, n_fail = 0, wr_cnt = 0, req_cnt = 0, hold_err = 0;
  int unsigned ptr;
  logic pend = 1'b0, pend_we = 1'b0;
  logic [31:0] pend_addr = '0;

  always @(negedge clk) begin
    mem_ready <= mem_req && ($urandom_range(0, 2) != 0);
    mem_rdata <= mem[mem_addr[11:2]];
  end

  always @(posedge clk) begin
    if (!rst_n) pend = 1'b0;
    else begin
      if (pend && (!mem_req || mem_addr != pend_addr || mem_we != pend_we)) hold_err++;
      pend = mem_req && !mem_ready;
      pend_addr = mem_addr;
      pend_we = mem_we;
      if (mem_req) req_cnt++;
      if (mem_req && mem_we && mem_ready) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[11:2]][8*i +: 8] = mem_wdata[8*i +: 8];
        wr_cnt++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic alt, logic [4:0] rs2, rs1, logic [2:0] f3, logic [4:0] rd);
    return {1'b0, alt, 5'd0, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2, rs1, logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] imm, logic [4:0] rs2, rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'h63};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6f};
  endfunction

  task automatic emit(input logic [31:0] w);
    mem[ptr[11:2]] = w;
    ptr += 4;
  endtask
  task automatic li(input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] hi;
    hi = v + 32'h800;
    emit({hi[31:12], rd, 7'h37});
    emit(enc_i(v[11:0], rd, 3'd0, rd, 7'h13));
  endtask
  task automatic sw_res(input logic [4:0] rs, input int slot);
    emit(enc_s(12'(RES + 4 * slot), rs, 5'd0, 3'd2));
  endtask
  task automatic begin_prog();
    ptr = RV;
    for (int i = 0; i < 64; i++) mem[(RES >> 2) + i] = 32'hdead_beef;
  endtask

  task automatic run(input bit chk_rst);
    rst_n = 1'b0;
    wr_cnt = 0;
    repeat (3) @(negedge clk);
    if (chk_rst) begin
      check("R1 halt in reset", {31'd0, halt}, 32'd0);
      check("R1 fault in reset", {31'd0, fault}, 32'd0);
      check("R2 first request", {31'd0, mem_req}, 32'd1);
      check("R2 first address", mem_addr, RV);
      check("R2 first is read", {31'd0, mem_we}, 32'd0);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (halt) break;
    end
    check("R10 program reached halt", {31'd0, halt}, 32'd1);
  endtask

  function automatic logic [31:0] alu_ref(logic [2:0] f3, logic alt, logic [31:0] a, b);
    case (f3)
      3'd0: return alt ? a - b : a + b;
      3'd1: return a << b[4:0];
      3'd2: return {31'd0, $signed(a) < $signed(b)};
      3'd3: return {31'd0, a < b};
      3'd4: return a ^ b;
      3'd5: return alt ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction
  function automatic logic [3:0] rsel(int k);  // {alt, f3}
    case (k)
      0: return 4'h0; 1: return 4'h8; 2: return 4'h1; 3: return 4'h2; 4: return 4'h3;
      5: return 4'h4; 6: return 4'h5; 7: return 4'hd; 8: return 4'h6; default: return 4'h7;
    endcase
  endfunction
  function automatic logic [3:0] isel(int k);
    case (k)
      0: return 4'h0; 1: return 4'h2; 2: return 4'h3; 3: return 4'h4; 4: return 4'h6;
      5: return 4'h7; 6: return 4'h1; 7: return 4'h5; default: return 4'hd;
    endcase
  endfunction
  function automatic bit br_ref(logic [2:0] f3, logic [31:0] a, b);
    case (f3)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      default: return a >= b;
    endcase
  endfunction
  function automatic logic [31:0] ld_ref(logic [2:0] f3, logic [31:0] w, logic [1:0] off);
    logic [31:0] s;
    s = w >> (8 * off);
    case (f3)
      3'd0: return {{24{s[7]}}, s[7:0]};
      3'd1: return {{16{s[15]}}, s[15:0]};
      3'd4: return {24'd0, s[7:0]};
      3'd5: return {16'd0, s[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic alu_run(input int n, input logic [31:0] a, b);
    logic [31:0] ex [19];
    logic [3:0] s;
    logic [11:0] imm;
    logic [31:0] bi;
    begin_prog();
    li(5'd1, a);
    li(5'd2, b);
    for (int k = 0; k < 10; k++) begin
      s = rsel(k);
      emit(enc_r(s[3], 5'd2, 5'd1, s[2:0], 5'd3));
      sw_res(5'd3, k);
      ex[k] = alu_ref(s[2:0], s[3], a, b);
    end
    for (int k = 0; k < 9; k++) begin
      s = isel(k);
      if (s[2:0] == 3'd1 || s[2:0] == 3'd5) begin
        imm = {1'b0, s[3], 5'd0, 5'($urandom_range(0, 31))};
        bi = {27'd0, imm[4:0]};
      end else begin
        imm = (n == 0) ? 12'hfff : 12'($urandom);
        bi = {{20{imm[11]}}, imm};
      end
      emit(enc_i(imm, 5'd1, s[2:0], 5'd3, 7'h13));
      sw_res(5'd3, 10 + k);
      ex[10 + k] = alu_ref(s[2:0], s[3] && s[2:0] == 3'd5, a, bi);
    end
    emit(32'h0010_0073);
    run(n == 0);
    for (int k = 0; k < 19; k++) check($sformatf("R3 alu op %0d run %0d", k, n), mem[(RES >> 2) + k], ex[k]);
    check("R10 ebreak no fault", {31'd0, fault}, 32'd0);
  endtask

  task automatic br_run(input logic [31:0] a, b);
    logic [2:0] fl [6] = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
    begin_prog();
    li(5'd1, a);
    li(5'd2, b);
    for (int k = 0; k < 6; k++) begin
      emit(enc_i(12'd0, 5'd0, 3'd0, 5'd4, 7'h13));
      emit(enc_b(13'd8, 5'd2, 5'd1, fl[k]));
      emit(enc_i(12'd1, 5'd0, 3'd0, 5'd4, 7'h13));
      sw_res(5'd4, k);
    end
    emit(32'h0010_0073);
    run(1'b0);
    for (int k = 0; k < 6; k++)
      check($sformatf("R5 branch f3=%0d", fl[k]), mem[(RES >> 2) + k], br_ref(fl[k], a, b) ? 32'd0 : 32'd1);
  endtask

  initial begin
    logic [31:0] p, j, q, v, snap;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0000_0013;

    alu_run(0, 32'h8000_0000, 32'h0000_0001);
    alu_run(1, 32'hffff_ffff, 32'h0000_0023);
    alu_run(2, 32'h7fff_ffff, 32'h7fff_ffff);
    for (int n = 3; n < 10; n++) alu_run(n, $urandom, $urandom);

    br_run(32'h0000_1234, 32'h0000_1234);
    br_run(32'hffff_ffff, 32'h0000_0001);
    for (int n = 0; n < 4; n++) br_run($urandom, $urandom);

    // jumps, U-type, x0, reset-cleared register
    begin_prog();
    sw_res(5'd13, 0);
    p = ptr; emit({20'h12345, 5'd5, 7'h17}); sw_res(5'd5, 1);
    emit({20'habcde, 5'd6, 7'h37}); sw_res(5'd6, 2);
    j = ptr; emit(enc_j(21'd8, 5'd7)); emit(enc_i(12'd1, 5'd0, 3'd0, 5'd8, 7'h13));
    sw_res(5'd7, 3); sw_res(5'd8, 4);
    q = ptr + 8; li(5'd9, q + 7);
    emit(enc_i(12'd2, 5'd9, 3'd0, 5'd10, 7'h67));
    emit(enc_i(12'd1, 5'd0, 3'd0, 5'd11, 7'h13));
    sw_res(5'd10, 5); sw_res(5'd11, 6);
    emit(enc_i(12'd5, 5'd0, 3'd0, 5'd0, 7'h13)); sw_res(5'd0, 7);
    emit(enc_j(21'd8, 5'd0)); emit(enc_i(12'd1, 5'd0, 3'd0, 5'd12, 7'h13)); sw_res(5'd12, 8);
    emit(32'h0000_0073);
    run(1'b0);
    check("R1 register cleared by reset", mem[(RES >> 2) + 0], 32'd0);
    check("R4 auipc", mem[(RES >> 2) + 1], p + 32'h1234_5000);
    check("R4 lui", mem[(RES >> 2) + 2], 32'habcd_e000);
    check("R6 jal link", mem[(RES >> 2) + 3], j + 4);
    check("R6 jal skipped slot", mem[(RES >> 2) + 4], 32'd0);
    check("R6 jalr link", mem[(RES >> 2) + 5], q + 4);
    check("R6 jalr bit0 cleared target", mem[(RES >> 2) + 6], 32'd0);
    check("R9 x0 stays zero", mem[(RES >> 2) + 7], 32'd0);
    check("R6 jal rd=x0 skip", mem[(RES >> 2) + 8], 32'd0);
    check("R10 ecall no fault", {31'd0, fault}, 32'd0);
    snap = req_cnt;
    repeat (10) @(negedge clk);
    check("R10 no request after halt", req_cnt, snap);

    // loads and stores
    for (int r = 0; r < 3; r++) begin
      logic [2:0] lf [13] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd4, 3'd4, 3'd4, 3'd1, 3'd1, 3'd5, 3'd5, 3'd2};
      logic [1:0] lo [13] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd2, 2'd0, 2'd2, 2'd0};
      logic [31:0] dw;
      dw = (r == 0) ? 32'h80ff_7f01 : $urandom;
      v = $urandom;
      mem['h500 >> 2] = dw;
      mem['h520 >> 2] = 32'h1122_3344;
      mem['h524 >> 2] = 32'h5566_7788;
      mem['h528 >> 2] = 32'h0;
      begin_prog();
      for (int k = 0; k < 13; k++) begin
        emit(enc_i(12'('h500 + lo[k]), 5'd0, lf[k], 5'd3, 7'h03));
        sw_res(5'd3, k);
      end
      li(5'd1, v);
      emit(enc_s(12'h521, 5'd1, 5'd0, 3'd0));
      emit(enc_s(12'h526, 5'd1, 5'd0, 3'd1));
      emit(enc_s(12'h528, 5'd1, 5'd0, 3'd2));
      emit(32'h0010_0073);
      run(1'b0);
      for (int k = 0; k < 13; k++)
        check($sformatf("R7 load f3=%0d off=%0d", lf[k], lo[k]), mem[(RES >> 2) + k], ld_ref(lf[k], dw, lo[k]));
      check("R8 sb lane 1", mem['h520 >> 2], {16'h1122, v[7:0], 8'h44});
      check("R8 sh upper half", mem['h524 >> 2], {v[15:0], 16'h7788});
      check("R8 sw word", mem['h528 >> 2], v);
    end

    // misaligned accesses
    for (int m = 0; m < 3; m++) begin
      mem['h528 >> 2] = 32'hcafe_f00d;
      mem['h520 >> 2] = 32'h1357_9bdf;
      begin_prog();
      li(5'd1, 32'h5a5a_5a5a);
      case (m)
        0: emit(enc_s(12'h52a, 5'd1, 5'd0, 3'd2));
        1: emit(enc_i(12'h501, 5'd0, 3'd1, 5'd1, 7'h03));
        default: emit(enc_s(12'h523, 5'd1, 5'd0, 3'd1));
      endcase
      sw_res(5'd1, 0);
      emit(32'h0010_0073);
      run(1'b0);
      check($sformatf("R11 fault case %0d", m), {31'd0, fault}, 32'd1);
      check($sformatf("R11 no write case %0d", m), wr_cnt, 32'd0);
      check("R11 word kept", mem['h528 >> 2], 32'hcafe_f00d);
      check("R11 half word kept", mem['h520 >> 2], 32'h1357_9bdf);
      check("R11 next instruction not run", mem[RES >> 2], 32'hdead_beef);
    end

    check("R12 request held while not ready", hold_err, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule